// File: doc/BRIEF.md
# Serial ADC Interface Mode Controller

This block models the digital side of a two-channel serial sampling converter. The host lowers chip select to begin a frame and then supplies serial clock pulses. On each falling clock edge the block takes in one bit of a command word on the data input and moves the next bit of a framed result onto the data output. The result value comes in on a parallel port from a stub, so no analog behaviour is modelled. All three serial pins are oversampled by the system clock through a synchronizer. The block acts on their edges one synchronizer delay later.

The block keeps track of three operating modes: normal, daisy-chain and power-down. Two things decide the mode. The first is the count of serial falling edges already seen when chip select goes high. The second is whether the two used command bits match. Leaving power-down takes one wake-up frame whose data is a dummy. A status output tells the host whether the next frame will carry valid data. The channel reported in a frame is the channel that an earlier command selected.

Top module: `serial_adc_ctrl`

## Requirements
- R1: After reset, `mode` is 00 (normal), `chan` is 0, `dout_oe` is 0 and `next_valid` is 1. `mode` only ever takes the codes 00 (normal), 01 (daisy-chain) and 10 (power-down).
- R2: A frame is 16 bits, MSB first. The bits are, in order: two zeros, the reported channel, the mode bit, then the `RES_BITS`-bit sample MSB first, then zero padding. The first bit appears when the chip-select fall is seen. Each serial falling edge in the frame moves `dout` on by one bit, and `dout` does not change at any other time.
- R3: `dout_oe` rises at the start of a frame. It falls when chip select rises or after the 16th serial falling edge, whichever comes first.
- R4: The mode bit, bit 12 of the frame, equals the reported channel in normal mode and is its inverse in daisy-chain mode.
- R5: Only the third and fourth command bits received are used: CHN (word bit 13) and STY (word bit 12). All other bits are ignored. CHN becomes the reported channel after any frame that ends with 10 or more edges while the block is not in power-down.
- R6: If chip select rises after fewer than 2 falling edges, the mode and channel do not change.
- R7: If chip select rises after 2 to 9 edges while the block is in normal or daisy-chain mode, it enters power-down. The channel is kept and `next_valid` goes to 0.
- R8: If chip select rises after 10, 11 or 12 edges while the block is not in power-down, it enters daisy-chain mode.
- R9: If a frame in normal mode ends with 13 to 16 edges, the block stays in normal mode, whatever the value of STY.
- R10: If a frame in daisy-chain mode ends with 13 to 16 edges, the block returns to normal when STY equals CHN and stays in daisy-chain mode otherwise.
- R11: In power-down, a frame that ends with 10 or more edges wakes the block: `mode` becomes 00 and `next_valid` becomes 1, and the channel is unchanged. A frame that ends with fewer than 10 edges leaves it in power-down.
- R12: Serial clock edges while chip select is high do not enable `dout` and do not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial command data |
| sample | input | RES_BITS | Parallel conversion result from the stub |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` (high means driven) |
| mode | output | 2 | Operating mode: 00 normal, 01 daisy-chain, 10 power-down |
| chan | output | 1 | Channel reported in the next frame |
| next_valid | output | 1 | High when the next frame carries valid data |

## Verification
The assertions assume that each serial pin holds every level for longer than the synchronizer depth plus one system clock. Under that assumption, every chip-select or serial-clock edge is seen once and only once. They also assume that `din` is settled before the serial falling edge that samples it. The bench holds every serial level for six system clocks and changes `din` only while the serial clock is high. It keeps `sample` constant from before the chip-select fall. The random frames cover every edge count from zero to sixteen, so every mode window is reached from every mode.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_CHAIN  = 2'b01,
    MODE_SLEEP  = 2'b10
  } op_mode_e;

  typedef struct packed {
    logic chn;
    logic sty;
  } cmd_t;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int                WIDTH   = 3,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_d
);

  // STAGES synchronizer flops plus one delayed copy for edge detection
  localparam int DEPTH = STAGES + 1;

  logic [WIDTH-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q   = pipe[STAGES-1];
  assign q_d = pipe[STAGES];

endmodule

// File: rtl/sadc_frame.sv
module sadc_frame import sadc_pkg::*; #(
  parameter int RES_BITS   = 12,
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = 5,
  parameter int CHN_EDGE   = 3,
  parameter int STY_EDGE   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                stop,
  input  logic                sclk_fall,
  input  logic                din,
  input  logic                chan,
  input  logic                mod_bit,
  input  logic [RES_BITS-1:0] sample,
  output logic                dout,
  output logic                active,
  output logic [CNT_W-1:0]    cnt,
  output logic                end_pulse,
  output logic [CNT_W-1:0]    end_cnt,
  output cmd_t                cmd
);

  localparam int HDR_BITS = 4;
  localparam int PAD      = FRAME_BITS - HDR_BITS - RES_BITS;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CPOS = CNT_W'(CHN_EDGE);
  localparam logic [CNT_W-1:0] SPOS = CNT_W'(STY_EDGE);

  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] word;
  logic                  fall_in;
  logic [CNT_W-1:0]      cnt_eff;

  assign word    = FRAME_BITS'({2'b00, chan, mod_bit, sample}) << PAD;
  assign fall_in = active & sclk_fall;
  assign cnt_eff = cnt + CNT_W'(fall_in);
  assign dout    = shreg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cnt       <= '0;
      active    <= 1'b0;
      end_pulse <= 1'b0;
      end_cnt   <= '0;
      cmd       <= '0;
    end else begin
      end_pulse <= 1'b0;
      if (active) begin
        if (fall_in) begin
          cnt   <= cnt_eff;
          shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
          if (cnt_eff == CPOS) cmd.chn <= din;
          if (cnt_eff == SPOS) cmd.sty <= din;
        end
        if (stop || (cnt_eff == LAST)) begin
          active    <= 1'b0;
          end_pulse <= 1'b1;
          end_cnt   <= cnt_eff;
          shreg     <= '0;
        end
      end else if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        shreg  <= word;
      end
    end
  end

endmodule

// File: rtl/sadc_mode_ctrl.sv
module sadc_mode_ctrl import sadc_pkg::*; #(
  parameter int CNT_W    = 5,
  parameter int PD_LO    = 2,
  parameter int CHAIN_LO = 10,
  parameter int CHAIN_HI = 12,
  parameter int WAKE_MIN = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             end_pulse,
  input  logic [CNT_W-1:0] end_cnt,
  input  cmd_t             cmd,
  output op_mode_e         mode_q,
  output logic             chan_q,
  output logic             valid_q
);

  localparam logic [CNT_W-1:0] T_PD   = CNT_W'(PD_LO);
  localparam logic [CNT_W-1:0] T_CLO  = CNT_W'(CHAIN_LO);
  localparam logic [CNT_W-1:0] T_CHI  = CNT_W'(CHAIN_HI);
  localparam logic [CNT_W-1:0] T_WAKE = CNT_W'(WAKE_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_NORMAL;
      chan_q  <= 1'b0;
      valid_q <= 1'b1;
    end else if (end_pulse) begin
      if (mode_q == MODE_SLEEP) begin
        if (end_cnt >= T_WAKE) begin
          mode_q  <= MODE_NORMAL;
          valid_q <= 1'b1;
        end
      end else if (end_cnt >= T_PD) begin
        if (end_cnt < T_CLO) begin
          mode_q  <= MODE_SLEEP;
          valid_q <= 1'b0;
        end else if (end_cnt <= T_CHI) begin
          mode_q <= MODE_CHAIN;
          chan_q <= cmd.chn;
        end else begin
          chan_q <= cmd.chn;
          if ((mode_q == MODE_CHAIN) && (cmd.sty == cmd.chn))
            mode_q <= MODE_NORMAL;
        end
      end
    end
  end

endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl import sadc_pkg::*; #(
  parameter int RES_BITS    = 12,
  parameter int FRAME_BITS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                din,
  input  logic [RES_BITS-1:0] sample,
  output logic                dout,
  output logic                dout_oe,
  output logic [1:0]          mode,
  output logic                chan,
  output logic                next_valid
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [2:0]       pin_s;
  logic [2:0]       pin_d;
  logic             cs_fall;
  logic             cs_rise;
  logic             sclk_fall;
  logic             frame_active;
  logic [CNT_W-1:0] frame_cnt;
  logic             end_pulse;
  logic [CNT_W-1:0] end_cnt;
  cmd_t             cmd;
  op_mode_e         mode_q;
  logic             mod_bit;

  sadc_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sclk, din}),
    .q   (pin_s),
    .q_d (pin_d)
  );

  assign cs_fall   =  pin_d[2] & ~pin_s[2];
  assign cs_rise   = ~pin_d[2] &  pin_s[2];
  assign sclk_fall =  pin_d[1] & ~pin_s[1];
  assign mod_bit   = (mode_q == MODE_CHAIN) ? ~chan : chan;

  sadc_frame #(
    .RES_BITS   (RES_BITS),
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .start     (cs_fall),
    .stop      (cs_rise),
    .sclk_fall (sclk_fall),
    .din       (pin_s[0]),
    .chan      (chan),
    .mod_bit   (mod_bit),
    .sample    (sample),
    .dout      (dout),
    .active    (frame_active),
    .cnt       (frame_cnt),
    .end_pulse (end_pulse),
    .end_cnt   (end_cnt),
    .cmd       (cmd)
  );

  sadc_mode_ctrl #(
    .CNT_W (CNT_W)
  ) u_mode (
    .clk       (clk),
    .rst       (rst),
    .end_pulse (end_pulse),
    .end_cnt   (end_cnt),
    .cmd       (cmd),
    .mode_q    (mode_q),
    .chan_q    (chan),
    .valid_q   (next_valid)
  );

  assign dout_oe = frame_active;
  assign mode    = mode_q;

endmodule

// File: rtl/sadc_checker.sv
module sadc_checker #(
  parameter int FRAME_BITS = 16
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              dout,
  input logic                              dout_oe,
  input logic [1:0]                        mode,
  input logic                              chan,
  input logic                              next_valid,
  input logic                              sclk_fall,
  input logic                              frame_active,
  input logic [$clog2(FRAME_BITS+1)-1:0]   frame_cnt
);

  localparam int CW = $clog2(FRAME_BITS + 1);

  assert_mode_code_R1: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b11);

  assert_dout_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && $past(dout_oe) && !$past(sclk_fall)) |-> $stable(dout));

  assert_oe_count_R3: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> (frame_cnt < CW'(FRAME_BITS)));

  assert_sleep_keeps_chan_R7: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'b10) && ($past(mode) != 2'b10)) |-> ((chan == $past(chan)) && !next_valid));

  assert_mode_between_frames_R6: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |-> !$past(frame_active));

  assert_valid_awake_R11: assert property (@(posedge clk) disable iff (rst)
    next_valid |-> (mode != 2'b10));

endmodule

bind serial_adc_ctrl sadc_checker #(.FRAME_BITS(FRAME_BITS)) u_sadc_chk (
  .clk          (clk),
  .rst          (rst),
  .dout         (dout),
  .dout_oe      (dout_oe),
  .mode         (mode),
  .chan         (chan),
  .next_valid   (next_valid),
  .sclk_fall    (sclk_fall),
  .frame_active (frame_active),
  .frame_cnt    (frame_cnt)
);

// File: tb/serial_adc_ctrl_bench.sv
module serial_adc_ctrl_bench;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [11:0] sample = '0;
  logic        dout, dout_oe, chan, next_valid;
  logic [1:0]  mode;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [1:0] m_mode  = 2'd0;
  logic       m_chan  = 1'b0;
  logic       m_valid = 1'b1;

  always #10 clk = ~clk;

  serial_adc_ctrl u_serial_adc_ctrl (
    .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .din (din),
    .sample (sample), .dout (dout), .dout_oe (dout_oe), .mode (mode),
    .chan (chan), .next_valid (next_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [1:0] md, input logic ch, input logic [11:0] s);
    logic mb;
    mb = (md == 2'd1) ? ~ch : ch;
    return {2'b00, ch, mb, s};
  endfunction

  task automatic model_end(input int n, input logic c, input logic s);
    if (m_mode == 2'd2) begin
      if (n >= 10) begin m_mode = 2'd0; m_valid = 1'b1; end
    end else if (n >= 2) begin
      if (n < 10) begin m_mode = 2'd2; m_valid = 1'b0; end
      else if (n <= 12) begin m_mode = 2'd1; m_chan = c; end
      else begin
        if ((m_mode == 2'd1) && (s == c)) m_mode = 2'd0;
        m_chan = c;
      end
    end
  endtask

  // one frame of nf falling edges; command bits 13/12 carry CHN/STY
  task automatic do_frame(input string req, input int nf, input logic c, input logic s);
    logic [15:0] cmd, got, exp, mask;
    logic        oe_start, oe_last;
    logic [11:0] smp;
    int          m;
    cmd = 16'($urandom);
    cmd[13] = c;
    cmd[12] = s;
    smp = 12'($urandom);
    exp = exp_word(m_mode, m_chan, smp);
    @(negedge clk);
    sample = smp;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    got = '0;
    got[15] = dout;
    oe_start = dout_oe;
    for (int k = 1; k <= nf; k++) begin
      din = cmd[16-k];
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      if (k < 16) got[15-k] = dout;
      sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    oe_last = dout_oe;
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    m = (nf < 15) ? nf : 15;
    mask = 16'hFFFF << (15 - m);
    if (m_mode != 2'd2) check({req, "/R2 frame bits"}, 32'(got & mask), 32'(exp & mask));
    check({req, "/R3 oe at start"}, 32'(oe_start), 32'd1);
    check({req, "/R3 oe before cs rise"}, 32'(oe_last), (nf < 16) ? 32'd1 : 32'd0);
    check({req, "/R3 oe after cs rise"}, 32'(dout_oe), 32'd0);
    model_end(nf, c, s);
    check({req, " mode"}, 32'(mode), 32'(m_mode));
    check({req, " chan"}, 32'(chan), 32'(m_chan));
    check({req, " next_valid"}, 32'(next_valid), 32'(m_valid));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode", 32'(mode), 32'd0);
    check("R1 chan", 32'(chan), 32'd0);
    check("R1 oe", 32'(dout_oe), 32'd0);
    check("R1 valid", 32'(next_valid), 32'd1);

    // R12 serial clocks with chip select high
    for (int k = 0; k < 20; k++) begin
      din = 1'($urandom);
      repeat (HALF) @(negedge clk);
      sclk = ~sclk;
      check("R12 oe idle", 32'(dout_oe), 32'd0);
    end
    sclk = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    check("R12 mode idle", 32'(mode), 32'd0);

    // R5 / R4 / R9 full frames in normal mode
    do_frame("R5 select ch1", 16, 1'b1, 1'b1);
    do_frame("R4 normal mod bit", 16, 1'b0, 1'b0);
    do_frame("R9 sty differs stays normal", 16, 1'b1, 1'b0);
    do_frame("R9 abort at 13", 13, 1'b0, 1'b1);
    // R6 early rise
    do_frame("R6 zero edges", 0, 1'b1, 1'b1);
    do_frame("R6 one edge", 1, 1'b1, 1'b0);
    // R8 daisy-chain entry at the window limits
    do_frame("R8 rise at 10", 10, 1'b1, 1'b0);
    do_frame("R4 daisy mod bit", 16, 1'b0, 1'b1);
    do_frame("R10 sty differs stays daisy", 16, 1'b1, 1'b0);
    do_frame("R10 sty equal to normal", 16, 1'b0, 1'b0);
    do_frame("R8 rise at 12", 12, 1'b1, 1'b1);
    do_frame("R7 daisy to sleep", 5, 1'b0, 1'b0);
    do_frame("R11 short wake stays asleep", 9, 1'b1, 1'b1);
    do_frame("R11 wake at 10", 10, 1'b1, 1'b1);
    do_frame("R7 rise at 2", 2, 1'b0, 1'b0);
    do_frame("R11 full wake", 16, 1'b0, 1'b0);
    do_frame("R8 rise at 11", 11, 1'b0, 1'b1);
    do_frame("R7 rise at 9", 9, 1'b1, 1'b0);
    do_frame("R11 wake", 13, 1'b0, 1'b1);

    // random frames over all edge counts
    for (int i = 0; i < 50; i++) begin
      int nf;
      nf = (($urandom % 4) == 0) ? 16 : int'($urandom % 17);
      do_frame("R10 random", nf, 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule